// File: doc/BRIEF.md
# Per-Input Circular Page Recorder

This block keeps a separate circular recording region, measured in whole memory pages, for each of up to twelve signal inputs sharing one page-addressed memory. Page indices are 21 bits wide, covering a memory of 2M pages. Software gives each input a first page and a region length in pages. Each time an input finishes filling a page, it pulses a completion strobe. The block then issues the physical page address for that page and moves the input's write offset forward, wrapping back to the first page of the region. The block counts how many pages hold data, up to the region length. Dropping an input's record enable stops its recording at once.

For readout, a caller names an input, a page of interest inside that input's region, and how many pages before and after that page it wants. The block trims both counts to the pages that actually hold data. It then produces the physical page addresses one per cycle, oldest first, with a countdown of pages still to come. The memory bus and the data path lie outside the block.

Top module: `page_ring_recorder`

## Requirements
- R1: After reset, no write or read address is issued, no input is recording or retrieving, no input is full, and every last-page output reads 0.
- R2: An input whose page count is 0 never starts recording and never receives a write address, whatever its record enable and completion strobes do.
- R3: A write address is the input's start page plus its write offset, taken modulo 2^21. The offset counts 0, 1, … up to page count − 1 and then returns to 0.
- R4: Completion requests from several recording inputs are granted one per cycle, lowest input index first. Ungranted requests stay pending, one per input. A request granted in cycle t appears on the write outputs in cycle t+1.
- R5: While record enable of an input is low, that input is not recording. A request pending or arriving in a cycle where its enable is low produces no write, and the request is discarded.
- R6: When record enable is high and the input is allocated but not recording, recording begins on the next clock. The write offset and the recorded count restart from 0, so the first write goes to the start page and the full flag clears.
- R7: The recorded count goes up by one per write until it equals the page count. The full flag is high exactly when the count equals a nonzero page count. Later writes overwrite the oldest page.
- R8: The last-page output of an input holds the address of its most recent write.
- R9: An accepted retrieval trims the pre count to the recorded pages older than the requested page, and the post count to the recorded pages newer than it. From the next cycle, the block emits pre+post+1 page addresses, one per cycle. It starts at the oldest page of the window and wraps inside the region. The remaining output reads the number of pages still to follow.
- R10: A retrieval request is ignored in any of these cases: a retrieval is already in progress; the input is unallocated, recording, or has its record enable high; the requested page lies outside its region or holds no data. At most one input is marked retrieving at a time.
- R11: An input being retrieved does not start recording, even with record enable high. It starts once the retrieval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | N_IN*PW | Start page of each input's region, input i in bits [i*PW +: PW] |
| cfg_pages | input | N_IN*PW | Region length in pages of each input, 0 = unallocated |
| record_en | input | N_IN | Level enable to record, one bit per input |
| page_done | input | N_IN | One-cycle strobe: the input has a completed page to store |
| wr_valid | output | 1 | A write page address is presented |
| wr_input | output | IW | Input owning the write address |
| wr_page | output | PW | Physical page to write |
| ret_req | input | 1 | One-cycle retrieval request strobe |
| ret_input | input | IW | Input to retrieve |
| ret_page | input | PW | Physical page of interest |
| ret_pre | input | PW | Pages wanted before the page of interest |
| ret_post | input | PW | Pages wanted after the page of interest |
| rd_valid | output | 1 | A read page address is presented |
| rd_input | output | IW | Input being read |
| rd_page | output | PW | Physical page to read |
| rd_remaining | output | PW | Pages still to follow this one |
| recording | output | N_IN | Per-input recording status |
| retrieving | output | N_IN | Per-input retrieving status |
| full | output | N_IN | Per-input region-full flag |
| last_page | output | N_IN*PW | Most recently written page of each input |

## Verification
The two functions that can fall in the same cycle are the arbiter granting a completion request and the freeze of that same input. They meet when a completion strobe and a falling record enable are driven together, or when enables are toggled at random while strobes keep arriving. The bench judges the result by requiring no write for the frozen input, both in that cycle and in the cycle after. A second overlap is a retrieval in progress while the retrieved input's record enable rises. Here the recording status must stay low until the last read address has left the block.

// File: rtl/page_ring_recorder.sv
module page_ring_recorder #(
  parameter int N_IN = 12,
  parameter int PW   = 21,
  localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN*PW-1:0] cfg_start,
  input  logic [N_IN*PW-1:0] cfg_pages,
  input  logic [N_IN-1:0]   record_en,
  input  logic [N_IN-1:0]   page_done,
  output logic              wr_valid,
  output logic [IW-1:0]     wr_input,
  output logic [PW-1:0]     wr_page,
  input  logic              ret_req,
  input  logic [IW-1:0]     ret_input,
  input  logic [PW-1:0]     ret_page,
  input  logic [PW-1:0]     ret_pre,
  input  logic [PW-1:0]     ret_post,
  output logic              rd_valid,
  output logic [IW-1:0]     rd_input,
  output logic [PW-1:0]     rd_page,
  output logic [PW-1:0]     rd_remaining,
  output logic [N_IN-1:0]   recording,
  output logic [N_IN-1:0]   retrieving,
  output logic [N_IN-1:0]   full,
  output logic [N_IN*PW-1:0] last_page
);

  logic [PW-1:0] st_a [N_IN];
  logic [PW-1:0] np_a [N_IN];
  logic [PW-1:0] wp_q [N_IN];
  logic [PW-1:0] cnt_q [N_IN];
  logic [PW-1:0] last_q [N_IN];
  logic [N_IN-1:0] rec_q, pend_q, req, gnt;
  logic [IW-1:0] gidx;

  logic          rv_act;
  logic [IW-1:0] rv_in;
  logic [PW-1:0] rv_off, rv_left;

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    assign st_a[g] = cfg_start[g*PW +: PW];
    assign np_a[g] = cfg_pages[g*PW +: PW];
    assign last_page[g*PW +: PW] = last_q[g];
    assign full[g] = (np_a[g] != '0) && (cnt_q[g] == np_a[g]);
    assign retrieving[g] = rv_act && (rv_in == IW'(g));
  end

  assign recording = rec_q;
  assign req = (pend_q | page_done) & rec_q & record_en;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt  = '0;
        gnt[i] = 1'b1;
        gidx = IW'(i);
      end
    end
  end

  logic [PW-1:0] r_st, r_np, r_wp, r_cnt, v_st, v_np;
  logic          r_rec, r_en;
  always_comb begin
    r_st = '0; r_np = '0; r_wp = '0; r_cnt = '0; r_rec = 1'b0; r_en = 1'b0;
    v_st = '0; v_np = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (ret_input == IW'(i)) begin
        r_st  = st_a[i];
        r_np  = np_a[i];
        r_wp  = wp_q[i];
        r_cnt = cnt_q[i];
        r_rec = rec_q[i];
        r_en  = record_en[i];
      end
      if (rv_in == IW'(i)) begin
        v_st = st_a[i];
        v_np = np_a[i];
      end
    end
  end

  logic [PW-1:0] r_off, r_top, r_age, r_old, pre_e, post_e, r_first, r_len;
  logic          r_inreg, r_accept;

  assign r_off   = ret_page - r_st;
  assign r_inreg = (ret_page >= r_st) && (r_off < r_np);
  assign r_top   = (r_wp == '0) ? r_np - 1'b1 : r_wp - 1'b1;
  assign r_age   = r_top - r_off + ((r_top >= r_off) ? '0 : r_np);
  assign r_old   = r_cnt - 1'b1 - r_age;
  assign pre_e   = (ret_pre < r_old) ? ret_pre : r_old;
  assign post_e  = (ret_post < r_age) ? ret_post : r_age;
  assign r_first = r_off - pre_e + ((r_off >= pre_e) ? '0 : r_np);
  assign r_len   = pre_e + post_e + 1'b1;
  assign r_accept = ret_req && !rv_act && (r_np != '0) && !r_rec && !r_en
                  && r_inreg && (r_age < r_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= '0;
      pend_q <= '0;
      for (int i = 0; i < N_IN; i++) begin
        wp_q[i]   <= '0;
        cnt_q[i]  <= '0;
        last_q[i] <= '0;
      end
    end else begin
      pend_q <= (pend_q | page_done) & rec_q & record_en & ~gnt;
      for (int i = 0; i < N_IN; i++) begin
        if (!record_en[i]) begin
          rec_q[i] <= 1'b0;
        end else if (!rec_q[i] && (np_a[i] != '0) && !retrieving[i]) begin
          rec_q[i] <= 1'b1;
          wp_q[i]  <= '0;
          cnt_q[i] <= '0;
        end else if (gnt[i]) begin
          last_q[i] <= st_a[i] + wp_q[i];
          wp_q[i]   <= (wp_q[i] == np_a[i] - 1'b1) ? '0 : wp_q[i] + 1'b1;
          if (cnt_q[i] != np_a[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_input <= '0;
      wr_page  <= '0;
    end else begin
      wr_valid <= |gnt;
      if (|gnt) begin
        wr_input <= gidx;
        wr_page  <= r_sel_page(gidx);
      end
    end
  end

  function automatic logic [PW-1:0] r_sel_page(input logic [IW-1:0] k);
    logic [PW-1:0] p;
    p = '0;
    for (int i = 0; i < N_IN; i++)
      if (k == IW'(i)) p = st_a[i] + wp_q[i];
    return p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_act  <= 1'b0;
      rv_in   <= '0;
      rv_off  <= '0;
      rv_left <= '0;
    end else if (r_accept) begin
      rv_act  <= 1'b1;
      rv_in   <= ret_input;
      rv_off  <= r_first;
      rv_left <= r_len;
    end else if (rv_act) begin
      if (rv_left == 1) rv_act <= 1'b0;
      rv_off  <= (rv_off == v_np - 1'b1) ? '0 : rv_off + 1'b1;
      rv_left <= rv_left - 1'b1;
    end
  end

  assign rd_valid     = rv_act;
  assign rd_input     = rv_in;
  assign rd_page      = v_st + rv_off;
  assign rd_remaining = rv_left - 1'b1;

endmodule

// File: rtl/page_ring_recorder_chk.sv
module page_ring_recorder_chk #(
  parameter int N_IN = 12,
  parameter int PW   = 21,
  localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_IN*PW-1:0] cfg_start,
  input logic [N_IN*PW-1:0] cfg_pages,
  input logic [N_IN-1:0]    record_en,
  input logic               wr_valid,
  input logic [IW-1:0]      wr_input,
  input logic [PW-1:0]      wr_page,
  input logic               rd_valid,
  input logic [IW-1:0]      rd_input,
  input logic [PW-1:0]      rd_page,
  input logic [PW-1:0]      rd_remaining,
  input logic [N_IN-1:0]    recording,
  input logic [N_IN-1:0]    retrieving
);

  logic [PW-1:0] w_st, w_np, q_st, q_np;
  always_comb begin
    w_st = '0; w_np = '0; q_st = '0; q_np = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (wr_input == IW'(i)) begin
        w_st = cfg_start[i*PW +: PW];
        w_np = cfg_pages[i*PW +: PW];
      end
      if (rd_input == IW'(i)) begin
        q_st = cfg_start[i*PW +: PW];
        q_np = cfg_pages[i*PW +: PW];
      end
    end
  end

  a_r2_no_unalloc_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (w_np != '0));

  a_r3_write_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_page - w_st) < w_np));

  a_r5_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> |($past(record_en) & (N_IN'(1) << wr_input)));

  a_r9_read_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_page - q_st) < q_np));

  a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_remaining != '0) |=>
      (rd_valid && rd_remaining == $past(rd_remaining) - 1'b1));

  a_r10_single_retrieval: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retrieving));

  a_r11_no_record_while_read: assert property (@(posedge clk) disable iff (!rst_n)
    (recording & retrieving) == '0);

endmodule

bind page_ring_recorder page_ring_recorder_chk #(.N_IN(N_IN), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_pages(cfg_pages),
  .record_en(record_en), .wr_valid(wr_valid), .wr_input(wr_input),
  .wr_page(wr_page), .rd_valid(rd_valid), .rd_input(rd_input),
  .rd_page(rd_page), .rd_remaining(rd_remaining), .recording(recording),
  .retrieving(retrieving)
);

// File: tb/sim_page_ring_recorder.sv
`timescale 1ns/1ps
module sim_page_ring_recorder;
  localparam int N = 12;
  localparam int PW = 21;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N*PW-1:0] cfg_start, cfg_pages, last_page;
  logic [N-1:0] recen = '0, pdone = '0;
  logic rreq = 1'b0;
  logic [IW-1:0] rin = '0;
  logic [PW-1:0] rpage = '0, rpre = '0, rpost = '0;
  logic wr_valid, rd_valid;
  logic [IW-1:0] wr_input, rd_input;
  logic [PW-1:0] wr_page, rd_page, rd_remaining;
  logic [N-1:0] recording, retrieving, full;

  logic [PW-1:0] ms [N], mn [N], mwp [N], mcnt [N], mlast [N];
  logic [N-1:0] mrec = '0, mpend = '0;
  bit mwv = 0, mra = 0;
  int mwi = 0, mri = 0;
  logic [PW-1:0] mwpg = '0, mroff = '0, mrleft = '0;
  int vec = 0, fails = 0;

  always_comb
    for (int i = 0; i < N; i++) begin
      cfg_start[i*PW +: PW] = ms[i];
      cfg_pages[i*PW +: PW] = mn[i];
    end

  page_ring_recorder #(.N_IN(N), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_pages(cfg_pages),
    .record_en(recen), .page_done(pdone), .wr_valid(wr_valid),
    .wr_input(wr_input), .wr_page(wr_page), .ret_req(rreq), .ret_input(rin),
    .ret_page(rpage), .ret_pre(rpre), .ret_post(rpost), .rd_valid(rd_valid),
    .rd_input(rd_input), .rd_page(rd_page), .rd_remaining(rd_remaining),
    .recording(recording), .retrieving(retrieving), .full(full),
    .last_page(last_page));

  task automatic chk(string r, logic [63:0] a, logic [63:0] e);
    vec++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  function automatic int mini(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_step();
    int g = -1;
    bit acc = 0;
    int first = 0, len = 0;
    for (int i = 0; i < N; i++)
      if (g < 0 && (mpend[i] | pdone[i]) && mrec[i] && recen[i]) g = i;
    if (rreq && !mra && int'(rin) < N) begin
      int n = int'(mn[rin]);
      int o = int'(rpage) - int'(ms[rin]);
      if (n != 0 && !mrec[rin] && !recen[rin] && o >= 0 && o < n) begin
        int age = ((int'(mwp[rin]) - 1 - o) % n + n) % n;
        if (age < int'(mcnt[rin])) begin
          int pre = mini(int'(rpre), int'(mcnt[rin]) - 1 - age);
          int post = mini(int'(rpost), age);
          first = ((o - pre) % n + n) % n;
          len = pre + post + 1;
          acc = 1;
        end
      end
    end
    mwv = (g >= 0);
    if (g >= 0) begin
      mwi = g;
      mwpg = ms[g] + mwp[g];
    end
    for (int i = 0; i < N; i++) begin
      bit oldrec = mrec[i];
      bit retr = mra && (mri == i);
      if (!recen[i]) mrec[i] = 0;
      else if (!mrec[i] && mn[i] != 0 && !retr) begin
        mrec[i] = 1; mwp[i] = 0; mcnt[i] = 0;
      end else if (g == i) begin
        mlast[i] = ms[i] + mwp[i];
        mwp[i] = (mwp[i] + 1 == mn[i]) ? '0 : mwp[i] + 1'b1;
        if (mcnt[i] != mn[i]) mcnt[i] = mcnt[i] + 1'b1;
      end
      mpend[i] = (mpend[i] | pdone[i]) & oldrec & recen[i] & (g != i);
    end
    if (acc) begin
      mra = 1; mri = int'(rin); mroff = PW'(first); mrleft = PW'(len);
    end else if (mra) begin
      if (mrleft == 1) mra = 0;
      mroff = (mroff + 1 == mn[mri]) ? '0 : mroff + 1'b1;
      mrleft = mrleft - 1'b1;
    end
  endtask

  task automatic check_outputs();
    chk("R4 wr_valid", wr_valid, mwv);
    if (mwv) begin
      chk("R4 wr_input", wr_input, mwi);
      chk("R3 wr_page", wr_page, mwpg);
    end
    chk("R6 recording", recording, mrec);
    for (int i = 0; i < N; i++) begin
      chk("R7 full", full[i], (mn[i] != 0) && (mcnt[i] == mn[i]));
      chk("R8 last_page", last_page[i*PW +: PW], mlast[i]);
      chk("R10 retrieving", retrieving[i], mra && mri == i);
    end
    chk("R9 rd_valid", rd_valid, mra);
    if (mra) begin
      chk("R9 rd_input", rd_input, mri);
      chk("R9 rd_page", rd_page, ms[mri] + mroff);
      chk("R9 rd_remaining", rd_remaining, mrleft - 1'b1);
    end
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    check_outputs();
    pdone = '0;
    rreq = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      ms[i] = '0; mn[i] = '0; mwp[i] = '0; mcnt[i] = '0; mlast[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 recording", recording, 0);
    chk("R1 retrieving", retrieving, 0);
    chk("R1 full", full, 0);
    chk("R1 last_page", last_page == '0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();

    for (int round = 0; round < 3; round++) begin
      for (int i = 0; i < N; i++) begin
        ms[i] = PW'($urandom % (2097152 - 8));
        mn[i] = PW'(1 + $urandom % 6);
      end
      mn[0] = 3; mn[3] = 0; mn[5] = 1;
      ms[11] = 21'd2097150; mn[11] = 2;
      recen = '1;
      step();

      pdone = '1;
      step();
      for (int i = 0; i < N; i++) begin
        if (i == 3) continue;
        chk("R4 priority order", wr_input, i);
        step();
      end
      step();
      chk("R7 single-page full", full[5], 1);

      pdone[0] = 1'b1; recen[0] = 1'b0;
      step();
      chk("R5 freeze same cycle", wr_valid, 0);
      step();
      chk("R5 pending dropped", wr_valid, 0);
      recen[0] = 1'b1;
      step();
      pdone[0] = 1'b1;
      step();
      chk("R6 restart at start", wr_page, ms[0]);
      chk("R6 full cleared", full[0], 0);

      rreq = 1'b1; rin = 0; rpage = ms[0]; rpre = 1; rpost = 1;
      step();
      step();
      chk("R10 busy input ignored", rd_valid, 0);

      for (int c = 0; c < 200; c++) begin
        for (int i = 0; i < N; i++) begin
          if ($urandom % 10 < 3) pdone[i] = 1'b1;
          if ($urandom % 64 == 0) recen[i] = ~recen[i];
        end
        step();
      end
      chk("R2 unallocated idle", recording[3], 0);

      recen = '0;
      step();
      step();
      for (int i = 0; i < N; i++) begin
        rin = IW'(i);
        rpage = ms[i] + PW'($urandom % (int'(mn[i]) + 1));
        rpre = PW'($urandom % 4);
        rpost = PW'($urandom % 4);
        rreq = 1'b1;
        step();
        for (int w = 0; w < 12 && mra; w++) begin
          if (w == 0) recen[i] = 1'b1;
          if ($urandom % 3 == 0) begin
            rreq = 1'b1; rin = IW'($urandom % N); rpage = ms[rin];
          end
          step();
          if (mra && mri == i) chk("R11 record held off", recording[i], 0);
        end
        recen = '0;
        step();
        step();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule